// File: doc/BRIEF.md
# Byte-handshake block transfer engine

This engine runs SMBus and I2C block transfers one byte at a time through a single data register. The surrounding host controller drives it in place of a block buffer. After every data byte the engine raises a byte-done flag and holds the bus. It moves on only when software writes 1 to that flag. Before releasing the engine on a write, software loads the next payload byte. On a read, software picks up the received byte before releasing the engine. On an SMBus block read, the count byte the target returns is captured into the data0 register. The final read byte gets a NACK when software has raised the last-byte control input, or when the captured count runs out.

Bit timing is left to a byte-level link below the engine. The engine asks the link to send a START with an address byte, send a byte, receive a byte (with ACK or NACK), or send a STOP. The link answers with a done pulse, which may carry a no-acknowledge or a lost-arbitration indication. Errors end the transfer early, and a kill input aborts it.

Top module: `blk_xfer_engine`

## Requirements
- R1: After reset the status byte, data0, the block data register and the link request are all zero. Status layout: bit0 byte done, bit1 interrupt, bit2 device error, bit3 bus error, bit4 failed, bit5 busy (read only), bits 7:6 zero.
- R2: A go pulse is accepted only when host configuration bit0 is 1, busy is 0 and byte done is 0. Otherwise it is ignored, with no status change and no link request. An accepted go sets busy and first requests a START (op 0) with the byte {address[7:1], 0}.
- R3: On an SMBus block write (address bit0 = 0, configuration bit2 = 0), the link gets these send requests (op 1) in order: the command register, data0 as the count, then one payload byte per step from the block data register. After each non-final payload byte, status reads 0x21 and no link request appears until software writes 1 to status bit0. Each payload byte is taken from the block data register at the moment it is sent.
- R4: With configuration bit2 = 1, a block write omits the count byte and sends the payload directly after the command. Data0 still sets the payload length.
- R5: On an SMBus block read (address bit0 = 1), the command is sent first. Then comes a repeated START with {address[7:1], 1}. Then a receive request (op 2) with ACK fetches the count into data0. Each following data byte lands in the block data register, with status 0x21 while paused.
- R6: A read data byte is NACKed when the last-byte input is 1 at the moment that byte is requested. A NACKed byte is followed by a STOP request (op 3).
- R7: An SMBus block read NACKs data byte number N on its own, where N is the count clamped to 1..MAX_BLK (count 0 gives 1). An illegal count therefore drains in at most MAX_BLK releases.
- R8: The I2C block read mode (i2c_rd_op = 1) sends hst_dat1 as the command instead of hst_cmd, and receives no count byte. The first received byte is a data byte, and only the last-byte input ends the read.
- R9: When the STOP after the final byte completes, byte done and interrupt are set and busy clears in the same cycle (status 0x03).
- R10: A no-acknowledge on an address, command, count or payload byte sets device error, requests STOP, then clears busy without setting byte done or interrupt.
- R11: Lost arbitration on any byte sets bus error and clears busy at once, with no STOP request.
- R12: A kill pulse during a transfer sets failed and clears busy, and no further link request is issued.
- R13: Status flags are write-1-to-clear: a 1 in the written byte clears that flag and a 0 leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| host_cfg | input | 8 | Host configuration: bit0 host enable, bit2 I2C mode for block writes |
| hst_addr | input | 8 | Target address in bits 7:1, direction in bit0 (1 = read) |
| hst_cmd | input | 8 | Command byte |
| hst_dat1 | input | 8 | Command byte used by the I2C block read mode |
| dat0_we | input | 1 | Software write strobe for data0 |
| dat0_wdata | input | 8 | Value written to data0 (write length) |
| blk_we | input | 1 | Software write strobe for the block data register |
| blk_wdata | input | 8 | Payload byte written by software |
| go | input | 1 | Start pulse |
| i2c_rd_op | input | 1 | Selects the I2C block read mode |
| last_byte | input | 1 | Request NACK and STOP on the next read byte |
| kill | input | 1 | Abort the running transfer |
| sts_we | input | 1 | Status write strobe |
| sts_wdata | input | 8 | Write-1-to-clear mask for the status flags |
| status | output | 8 | Status byte |
| dat0 | output | 8 | Data0 register (length, or received count) |
| blk_data | output | 8 | Block data register |
| lnk_req | output | 1 | One-cycle link request |
| lnk_op | output | 2 | Link operation: 0 START+address, 1 send, 2 receive, 3 STOP |
| lnk_byte | output | 8 | Byte to send |
| lnk_nack | output | 1 | Answer the received byte with NACK |
| lnk_done | input | 1 | Link finished the requested operation |
| lnk_rx | input | 8 | Received byte, valid with lnk_done |
| lnk_noack | input | 1 | Target did not acknowledge, valid with lnk_done |
| lnk_lost | input | 1 | Arbitration lost, valid with lnk_done |

## Verification
A link request appears one cycle after the go pulse, link done or byte-done release that causes it. Each request stays up for exactly one cycle, so the bench polls at falling edges until it sees it and then compares op, byte and NACK. A status or register result is registered on the edge that takes the link done or release. The bench reads it at the falling edge right after it drops that done pulse. To show that the engine stays quiet while paused, the bench watches lnk_req over several idle cycles and only then releases the byte.

// File: rtl/blk_xfer_engine.sv
module blk_xfer_engine #(
  parameter int MAX_BLK = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] host_cfg,
  input  logic [7:0] hst_addr,
  input  logic [7:0] hst_cmd,
  input  logic [7:0] hst_dat1,
  input  logic       dat0_we,
  input  logic [7:0] dat0_wdata,
  input  logic       blk_we,
  input  logic [7:0] blk_wdata,
  input  logic       go,
  input  logic       i2c_rd_op,
  input  logic       last_byte,
  input  logic       kill,
  input  logic       sts_we,
  input  logic [7:0] sts_wdata,
  output logic [7:0] status,
  output logic [7:0] dat0,
  output logic [7:0] blk_data,
  output logic       lnk_req,
  output logic [1:0] lnk_op,
  output logic [7:0] lnk_byte,
  output logic       lnk_nack,
  input  logic       lnk_done,
  input  logic [7:0] lnk_rx,
  input  logic       lnk_noack,
  input  logic       lnk_lost
);
  localparam int CW = $clog2(MAX_BLK + 1);
  localparam logic [1:0] OP_START = 2'd0, OP_TX = 2'd1, OP_RX = 2'd2, OP_STOP = 2'd3;

  typedef enum logic [3:0] {
    S_IDLE, S_ADR1, S_CMD, S_CNTW, S_PAY, S_ADR2, S_CNTR, S_RXB, S_HOLD, S_STOP
  } st_t;

  st_t           st;
  logic          issue, rd, i2crd, nocnt, nack_q, fin;
  logic          done, intr, dev, buse, fail;
  logic [6:0]    addr_q;
  logic [7:0]    cmd_q, dat0_q, blk_q;
  logic [CW-1:0] rem;
  logic          busy, release_w;

  function automatic logic [CW-1:0] eff_len(input logic [7:0] c);
    if (c == 8'd0) return CW'(1);
    if (int'(c) > MAX_BLK) return CW'(MAX_BLK);
    return CW'(c);
  endfunction

  assign busy      = (st != S_IDLE);
  assign release_w = sts_we && sts_wdata[0];
  assign status    = {2'b00, busy, fail, buse, dev, intr, done};
  assign dat0      = dat0_q;
  assign blk_data  = blk_q;
  assign lnk_req   = issue;

  always_comb begin
    lnk_op   = OP_TX;
    lnk_byte = 8'h00;
    lnk_nack = 1'b0;
    case (st)
      S_ADR1:  begin lnk_op = OP_START; lnk_byte = {addr_q, 1'b0}; end
      S_CMD:   lnk_byte = cmd_q;
      S_CNTW:  lnk_byte = dat0_q;
      S_PAY:   lnk_byte = blk_q;
      S_ADR2:  begin lnk_op = OP_START; lnk_byte = {addr_q, 1'b1}; end
      S_CNTR:  lnk_op = OP_RX;
      S_RXB:   begin lnk_op = OP_RX; lnk_nack = nack_q; end
      S_STOP:  lnk_op = OP_STOP;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; issue <= 1'b0; rd <= 1'b0; i2crd <= 1'b0; nocnt <= 1'b0;
      nack_q <= 1'b0; fin <= 1'b0; done <= 1'b0; intr <= 1'b0; dev <= 1'b0;
      buse <= 1'b0; fail <= 1'b0; addr_q <= '0; cmd_q <= '0; dat0_q <= '0;
      blk_q <= '0; rem <= '0;
    end else begin
      issue <= 1'b0;
      if (sts_we) begin
        done <= done & ~sts_wdata[0];
        intr <= intr & ~sts_wdata[1];
        dev  <= dev  & ~sts_wdata[2];
        buse <= buse & ~sts_wdata[3];
        fail <= fail & ~sts_wdata[4];
      end
      if (dat0_we) dat0_q <= dat0_wdata;
      if (blk_we)  blk_q  <= blk_wdata;

      if (kill && busy) begin
        st   <= S_IDLE;
        fail <= 1'b1;
      end else begin
        case (st)
          S_IDLE: if (go && host_cfg[0] && !done) begin
            addr_q <= hst_addr[7:1];
            rd     <= i2c_rd_op | hst_addr[0];
            i2crd  <= i2c_rd_op;
            nocnt  <= i2c_rd_op | host_cfg[2];
            cmd_q  <= i2c_rd_op ? hst_dat1 : hst_cmd;
            rem    <= eff_len(dat0_q);
            fin    <= 1'b0;
            st     <= S_ADR1;
            issue  <= 1'b1;
          end
          S_ADR1, S_CMD, S_CNTW, S_PAY, S_ADR2: if (lnk_done) begin
            if (lnk_lost) begin
              buse <= 1'b1;
              st   <= S_IDLE;
            end else if (lnk_noack) begin
              dev   <= 1'b1;
              fin   <= 1'b0;
              st    <= S_STOP;
              issue <= 1'b1;
            end else begin
              case (st)
                S_ADR1: begin st <= S_CMD; issue <= 1'b1; end
                S_CMD: begin
                  st    <= rd ? S_ADR2 : (nocnt ? S_PAY : S_CNTW);
                  issue <= 1'b1;
                end
                S_CNTW: begin st <= S_PAY; issue <= 1'b1; end
                S_ADR2: begin
                  issue <= 1'b1;
                  if (i2crd) begin
                    st     <= S_RXB;
                    nack_q <= last_byte;
                  end else begin
                    st <= S_CNTR;
                  end
                end
                default: begin
                  if (rem == CW'(1)) begin
                    st    <= S_STOP;
                    fin   <= 1'b1;
                    issue <= 1'b1;
                  end else begin
                    rem  <= rem - CW'(1);
                    st   <= S_HOLD;
                    done <= 1'b1;
                  end
                end
              endcase
            end
          end
          S_CNTR: if (lnk_done) begin
            if (lnk_lost) begin
              buse <= 1'b1;
              st   <= S_IDLE;
            end else begin
              dat0_q <= lnk_rx;
              rem    <= eff_len(lnk_rx);
              nack_q <= last_byte || (eff_len(lnk_rx) == CW'(1));
              st     <= S_RXB;
              issue  <= 1'b1;
            end
          end
          S_RXB: if (lnk_done) begin
            if (lnk_lost) begin
              buse <= 1'b1;
              st   <= S_IDLE;
            end else begin
              blk_q <= lnk_rx;
              if (nack_q) begin
                st    <= S_STOP;
                fin   <= 1'b1;
                issue <= 1'b1;
              end else begin
                rem  <= rem - CW'(1);
                st   <= S_HOLD;
                done <= 1'b1;
              end
            end
          end
          S_HOLD: if (release_w) begin
            issue <= 1'b1;
            if (rd) begin
              st     <= S_RXB;
              nack_q <= last_byte || (!i2crd && rem == CW'(1));
            end else begin
              st <= S_PAY;
            end
          end
          S_STOP: if (lnk_done) begin
            st <= S_IDLE;
            if (fin) begin
              done <= 1'b1;
              intr <= 1'b1;
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  AST_REQ_SINGLE:   assert property (@(posedge clk) disable iff (!rst_n) lnk_req |=> !lnk_req); // R2
  AST_PAUSE_QUIET:  assert property (@(posedge clk) disable iff (!rst_n) (busy && done) |-> !lnk_req); // R3
  AST_COUNT_TO_D0:  assert property (@(posedge clk) disable iff (!rst_n)
                      (st == S_CNTR && lnk_done && !lnk_lost && !kill) |=> dat0 == $past(lnk_rx)); // R5
  AST_NACK_RX_ONLY: assert property (@(posedge clk) disable iff (!rst_n) (lnk_req && lnk_nack) |-> lnk_op == OP_RX); // R6
  AST_END_FLAGS:    assert property (@(posedge clk) disable iff (!rst_n)
                      ($fell(busy) && !fail && !dev && !buse) |-> (done && intr)); // R9
  AST_IDLE_SILENT:  assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !lnk_req); // R12
endmodule

// File: tb/tb_blk_xfer_engine.sv
module tb_blk_xfer_engine;
  localparam int MAXB = 32;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] host_cfg = 8'h01, hst_addr = '0, hst_cmd = '0, hst_dat1 = '0;
  logic dat0_we = 0, blk_we = 0, go = 0, i2c_rd_op = 0, last_byte = 0, kill = 0, sts_we = 0;
  logic [7:0] dat0_wdata = '0, blk_wdata = '0, sts_wdata = '0;
  logic [7:0] status, dat0, blk_data, lnk_byte;
  logic lnk_req, lnk_nack;
  logic [1:0] lnk_op;
  logic lnk_done = 0, lnk_noack = 0, lnk_lost = 0;
  logic [7:0] lnk_rx = '0;
  int vectors = 0, fails = 0;

  always #5 clk = ~clk;

  blk_xfer_engine #(.MAX_BLK(MAXB)) dut (
    .clk(clk), .rst_n(rst_n), .host_cfg(host_cfg), .hst_addr(hst_addr), .hst_cmd(hst_cmd),
    .hst_dat1(hst_dat1), .dat0_we(dat0_we), .dat0_wdata(dat0_wdata), .blk_we(blk_we),
    .blk_wdata(blk_wdata), .go(go), .i2c_rd_op(i2c_rd_op), .last_byte(last_byte), .kill(kill),
    .sts_we(sts_we), .sts_wdata(sts_wdata), .status(status), .dat0(dat0), .blk_data(blk_data),
    .lnk_req(lnk_req), .lnk_op(lnk_op), .lnk_byte(lnk_byte), .lnk_nack(lnk_nack),
    .lnk_done(lnk_done), .lnk_rx(lnk_rx), .lnk_noack(lnk_noack), .lnk_lost(lnk_lost));

  task automatic chk(input string r, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", r, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int eff(input int c);
    if (c == 0) return 1;
    if (c > MAXB) return MAXB;
    return c;
  endfunction

  task automatic expect_req(input string r, input int op, input int b, input int nk);
    int t = 0;
    while (!lnk_req && t < 100) begin @(negedge clk); t++; end
    chk({r, " request"}, int'(lnk_req), 1);
    chk({r, " op"}, int'(lnk_op), op);
    if (op < 2) chk({r, " byte"}, int'(lnk_byte), b);
    if (op == 2) chk({r, " nack"}, int'(lnk_nack), nk);
  endtask

  task automatic reply(input logic [7:0] rx, input bit na, input bit lo);
    cyc($urandom_range(0, 3) + 1);
    lnk_rx = rx; lnk_noack = na; lnk_lost = lo; lnk_done = 1'b1;
    @(negedge clk);
    lnk_done = 1'b0; lnk_noack = 1'b0; lnk_lost = 1'b0;
  endtask

  task automatic w1c(input logic [7:0] m);
    sts_we = 1'b1; sts_wdata = m; @(negedge clk); sts_we = 1'b0;
  endtask

  task automatic quiet(input string r, input int n);
    for (int i = 0; i < n; i++) begin chk(r, int'(lnk_req), 0); cyc(1); end
  endtask

  task automatic setup_write(input logic [6:0] a, input logic [7:0] c, input int n,
                             input logic [7:0] first, input bit i2c);
    host_cfg = i2c ? 8'h05 : 8'h01; hst_addr = {a, 1'b0}; hst_cmd = c; i2c_rd_op = 1'b0;
    dat0_we = 1'b1; dat0_wdata = 8'(n); blk_we = 1'b1; blk_wdata = first;
    @(negedge clk);
    dat0_we = 1'b0; blk_we = 1'b0;
    go = 1'b1; @(negedge clk); go = 1'b0;
  endtask

  task automatic do_write(input int n, input bit i2c);
    logic [7:0] pl [64];
    logic [6:0] a = 7'($urandom_range(1, 127));
    logic [7:0] c = 8'($urandom);
    string rq = i2c ? "R4" : "R3";
    for (int i = 0; i < n; i++) pl[i] = 8'($urandom);
    setup_write(a, c, n, pl[0], i2c);
    expect_req("R2 start", 0, {a, 1'b0}, 0); reply(0, 0, 0);
    expect_req({rq, " cmd"}, 1, c, 0); reply(0, 0, 0);
    if (!i2c) begin expect_req("R3 count", 1, n, 0); reply(0, 0, 0); end
    for (int k = 0; k < n; k++) begin
      expect_req({rq, " payload"}, 1, pl[k], 0); reply(0, 0, 0);
      if (k < n - 1) begin
        chk("R3 paused status", int'(status), 8'h21);
        quiet("R3 quiet while paused", 3);
        blk_we = 1'b1; blk_wdata = pl[k + 1]; @(negedge clk); blk_we = 1'b0;
        w1c(8'h01);
      end else begin
        expect_req("R9 stop", 3, 0, 0); reply(0, 0, 0);
        chk("R9 end status", int'(status), 8'h03);
        w1c(8'h03);
        chk("R13 cleared", int'(status), 8'h00);
      end
    end
  endtask

  task automatic do_read_smb(input int cnt, input int stop_at);
    logic [7:0] d [64];
    logic [6:0] a = 7'($urandom_range(1, 127));
    logic [7:0] c = 8'($urandom);
    int e = eff(cnt);
    for (int i = 0; i < 64; i++) d[i] = 8'($urandom);
    host_cfg = 8'h01; hst_addr = {a, 1'b1}; hst_cmd = c; i2c_rd_op = 1'b0; last_byte = 1'b0;
    go = 1'b1; @(negedge clk); go = 1'b0;
    expect_req("R2 start", 0, {a, 1'b0}, 0); reply(0, 0, 0);
    expect_req("R5 cmd", 1, c, 0); reply(0, 0, 0);
    expect_req("R5 restart read", 0, {a, 1'b1}, 0); reply(0, 0, 0);
    expect_req("R5 count rx", 2, 0, 0); reply(8'(cnt), 0, 0);
    for (int k = 0; k < 64; k++) begin
      bit nk = (k == e - 1) || (stop_at >= 0 && k >= stop_at);
      expect_req(stop_at == k ? "R6 early nack" : "R7 data rx", 2, 0, int'(nk));
      reply(d[k], 0, 0);
      chk("R5 data byte", int'(blk_data), int'(d[k]));
      chk("R5 count in data0", int'(dat0), cnt & 8'hff);
      if (nk) begin
        expect_req("R6 stop", 3, 0, 0); reply(0, 0, 0);
        chk("R9 end status", int'(status), 8'h03);
        last_byte = 1'b0;
        w1c(8'h03);
        break;
      end
      chk("R5 paused status", int'(status), 8'h21);
      if (k + 1 == stop_at) last_byte = 1'b1;
      w1c(8'h01);
    end
  endtask

  task automatic do_read_i2c(input int n);
    logic [7:0] d [64];
    logic [6:0] a = 7'($urandom_range(1, 127));
    logic [7:0] c = 8'($urandom);
    for (int i = 0; i < n; i++) d[i] = 8'($urandom);
    host_cfg = 8'h01; hst_addr = {a, 1'b0}; hst_dat1 = c; hst_cmd = ~c; i2c_rd_op = 1'b1;
    last_byte = (n == 1);
    go = 1'b1; @(negedge clk); go = 1'b0;
    expect_req("R8 start dir0", 0, {a, 1'b0}, 0); reply(0, 0, 0);
    expect_req("R8 cmd from dat1", 1, c, 0); reply(0, 0, 0);
    expect_req("R8 restart read", 0, {a, 1'b1}, 0); reply(0, 0, 0);
    for (int k = 0; k < n; k++) begin
      expect_req("R8 data rx, no count", 2, 0, int'(k == n - 1)); reply(d[k], 0, 0);
      chk("R8 data byte", int'(blk_data), int'(d[k]));
      if (k == n - 1) begin
        expect_req("R6 stop", 3, 0, 0); reply(0, 0, 0);
        chk("R9 end status", int'(status), 8'h03);
        last_byte = 1'b0; i2c_rd_op = 1'b0;
        w1c(8'h03);
      end else begin
        chk("R8 paused status", int'(status), 8'h21);
        if (k + 1 == n - 1) last_byte = 1'b1;
        w1c(8'h01);
      end
    end
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1234));
    cyc(3);
    chk("R1 status", int'(status), 0);
    chk("R1 req", int'(lnk_req), 0);
    chk("R1 data0", int'(dat0), 0);
    chk("R1 blk", int'(blk_data), 0);
    rst_n = 1'b1;
    cyc(2);

    host_cfg = 8'h00; go = 1'b1; @(negedge clk); go = 1'b0;
    quiet("R2 disabled go ignored", 4);
    chk("R2 disabled status", int'(status), 0);

    do_write(1, 0);
    do_write(4, 0);
    do_write(3, 1);
    do_read_smb(3, -1);
    do_read_smb(0, -1);
    do_read_smb(40, -1);
    do_read_smb(6, 2);
    do_read_i2c(1);
    do_read_i2c(4);

    setup_write(7'h21, 8'h10, 2, 8'hAA, 0);
    expect_req("R10 start", 0, 8'h42, 0); reply(0, 1, 0);
    expect_req("R10 stop after noack", 3, 0, 0); reply(0, 0, 0);
    chk("R10 status", int'(status), 8'h04);
    w1c(8'h04);

    hst_addr = 8'h33; host_cfg = 8'h01; go = 1'b1; @(negedge clk); go = 1'b0;
    expect_req("R11 start", 0, 8'h32, 0); reply(0, 0, 0);
    expect_req("R11 cmd", 1, int'(hst_cmd), 0); reply(0, 0, 1);
    chk("R11 status", int'(status), 8'h08);
    quiet("R11 no stop", 4);
    w1c(8'h08);

    setup_write(7'h11, 8'h01, 3, 8'h5A, 0);
    expect_req("R12 start", 0, 8'h22, 0); reply(0, 0, 0);
    expect_req("R12 cmd", 1, 8'h01, 0); reply(0, 0, 0);
    expect_req("R12 count", 1, 3, 0); reply(0, 0, 0);
    expect_req("R12 payload", 1, 8'h5A, 0); reply(0, 0, 0);
    chk("R12 paused", int'(status), 8'h21);
    kill = 1'b1; @(negedge clk); kill = 1'b0;
    chk("R12 status after kill", int'(status), 8'h11);
    w1c(8'h01);
    chk("R13 partial clear", int'(status), 8'h10);
    quiet("R12 silent after kill", 4);
    w1c(8'h10);

    setup_write(7'h05, 8'h02, 1, 8'h77, 0);
    expect_req("R2 start", 0, 8'h0A, 0); reply(0, 0, 0);
    expect_req("R3 cmd", 1, 8'h02, 0); reply(0, 0, 0);
    expect_req("R3 count", 1, 1, 0); reply(0, 0, 0);
    expect_req("R3 payload", 1, 8'h77, 0); reply(0, 0, 0);
    expect_req("R9 stop", 3, 0, 0); reply(0, 0, 0);
    chk("R9 status", int'(status), 8'h03);
    go = 1'b1; @(negedge clk); go = 1'b0;
    quiet("R2 go ignored while done pending", 4);
    w1c(8'h00);
    chk("R13 zero write keeps flags", int'(status), 8'h03);
    w1c(8'h02);
    chk("R13 clear intr only", int'(status), 8'h01);
    w1c(8'h01);
    chk("R13 all clear", int'(status), 8'h00);

    for (int it = 0; it < 16; it++) begin
      case ($urandom_range(0, 3))
        0: do_write($urandom_range(1, 6), 0);
        1: do_write($urandom_range(1, 6), 1);
        2: do_read_smb($urandom_range(1, 6), -1);
        default: do_read_i2c($urandom_range(1, 5));
      endcase
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule